// File: doc/BRIEF.md
# Real-Time Clock Time Keeper with Update Window and Alarm

The block holds the time of day (seconds, minutes, hours) and the calendar (day of week, day of month, month, two-digit year). It advances them by one second each time an external divider delivers a one-second tick. Every advance is announced in advance: a pending flag rises as soon as the tick is accepted. The time registers then change a fixed number of clock cycles later. The flag stays high for a further fixed window that stands for the internal update time. When the window closes, a one-cycle completion pulse is produced.

Software reaches the registers through a single-cycle write port and a combinational read port. A control register selects the value encoding (packed BCD or plain binary) and the hour format (24-hour, or 12-hour with a PM flag in bit 7 of the hour byte). It also carries a hold bit that stops the clock so that a new time can be loaded safely. Three alarm bytes, one each for seconds, minutes and hours, are compared with the freshly updated time at the end of each window. A field programmed with both of its top bits set acts as a wildcard. The lengths of the warning window and the update window are parameters, counted in clock cycles.

Top module: `rtc_timekeeper`

## Requirements
- R1: The registers sit at these addresses: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 day of month, 8 month, 9 year. Each of these reads back the byte last written to it. Address 10 is read-only status, with bit 7 set while an update is pending and all other bits 0. Address 11 is control: bit 7 hold, bit 2 binary mode, bit 1 24-hour mode, other bits read 0. After reset, control reads 0x02, day of week, day of month and month read 1, and every other register reads 0.
- R2: A tick accepted at a clock edge sets the pending flag from that edge onward. The time registers change exactly WARN_CYCLES edges later. The flag stays high for WARN_CYCLES+UPD_CYCLES cycles in total.
- R3: `update_done` is high for exactly one cycle, the first cycle in which the pending flag is low again.
- R4: While the hold bit is 1, ticks are ignored. If the hold bit is 1 when the warning window ends, the sequence is dropped: the flag falls, the time stays unchanged and no completion pulse is produced.
- R5: A tick that arrives while an update is pending is ignored: it neither restarts nor extends the sequence.
- R6: Seconds and minutes count 0 to 59 and carry into the next field on wrap. In BCD mode (control bit 2 = 0) each byte holds two decimal digits, tens in bits 7:4. In binary mode each byte holds the plain value.
- R7: In 24-hour mode the hour counts 0 to 23, and 23 wraps to 0 with a carry into the date.
- R8: In 12-hour mode the hour counts 1 to 12, with bit 7 of the hour byte = 1 meaning PM. 11 goes to 12 and toggles PM, and 12 goes to 1 without toggling. The date advances only when 11 PM becomes 12 AM.
- R9: The day of month wraps to 1 after 28, 29, 30 or 31 depending on the month. February has 29 days when the year is a multiple of 4 (year 0 included). The month wraps 12 to 1 and carries into the year. The year wraps 99 to 0. Day of week counts 1 to 7 and wraps 7 to 1.
- R10: `alarm_hit` pulses together with `update_done` when the hour, minute and second alarm bytes each equal the updated time byte. It stays low otherwise.
- R11: An alarm byte whose bits 7 and 6 are both 1 matches any value of its time field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-second pulse from the divider, one clock wide |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| update_pending | output | 1 | High from the accepted tick until the update window closes |
| update_done | output | 1 | One-cycle pulse when an update completes |
| alarm_hit | output | 1 | One-cycle pulse when the updated time matches the alarm |

## Verification
The tick is driven on a falling edge, so the accepting rising edge is the next one. The pending flag is due in the first falling-edge sample after that edge. The time registers change at the sample WARN_CYCLES falling edges later. The completion and alarm pulses appear at the sample WARN_CYCLES+UPD_CYCLES falling edges after acceptance, and are gone one sample later. The bench counts falling edges from the tick exactly to those points before it reads anything. Its update task always samples the pulses at the final count, and register reads are taken combinationally between edges.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_AW = 4;
    localparam int DATA_W = 8;

    localparam logic [REG_AW-1:0] A_SEC     = 4'd0;
    localparam logic [REG_AW-1:0] A_SEC_AL  = 4'd1;
    localparam logic [REG_AW-1:0] A_MIN     = 4'd2;
    localparam logic [REG_AW-1:0] A_MIN_AL  = 4'd3;
    localparam logic [REG_AW-1:0] A_HOUR    = 4'd4;
    localparam logic [REG_AW-1:0] A_HOUR_AL = 4'd5;
    localparam logic [REG_AW-1:0] A_DOW     = 4'd6;
    localparam logic [REG_AW-1:0] A_DOM     = 4'd7;
    localparam logic [REG_AW-1:0] A_MON     = 4'd8;
    localparam logic [REG_AW-1:0] A_YEAR    = 4'd9;
    localparam logic [REG_AW-1:0] A_STAT    = 4'd10;
    localparam logic [REG_AW-1:0] A_CTRL    = 4'd11;

    localparam int CB_HOLD = 7;
    localparam int CB_BIN  = 2;
    localparam int CB_H24  = 1;
    localparam int SB_PEND = 7;
    localparam int HB_PM   = 7;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] dow;
        logic [DATA_W-1:0] dom;
        logic [DATA_W-1:0] mon;
        logic [DATA_W-1:0] year;
    } rtc_time_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WARN = 2'd1,
        PH_UPD  = 2'd2
    } phase_e;

    // Stored byte (BCD or binary) to plain binary value.
    function automatic logic [7:0] field_to_bin(input logic [7:0] v, input logic bin);
        if (bin) return v;
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

    // Plain binary value (0..99) to stored byte in the selected encoding.
    function automatic logic [7:0] field_from_bin(input logic [7:0] n, input logic bin);
        if (bin) return n;
        return {4'(n / 8'd10), 4'(n % 8'd10)};
    endfunction

    // Month length; month and year given as plain binary values.
    function automatic logic [7:0] days_in_month(input logic [7:0] m, input logic [7:0] y);
        logic [7:0] r;
        case (m)
            8'd2:                     r = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  r = 8'd30;
            default:                  r = 8'd31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_sequencer.sv
module rtc_sequencer
    import rtc_pkg::*;
#(
    parameter int WARN_CYCLES = 4,
    parameter int UPD_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    output logic busy,
    output logic apply,
    output logic finish,
    output logic done
);

    localparam int LONGEST = (WARN_CYCLES > UPD_CYCLES) ? WARN_CYCLES : UPD_CYCLES;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] WARN_LAST = CNT_W'(WARN_CYCLES - 1);
    localparam logic [CNT_W-1:0] UPD_LAST  = CNT_W'(UPD_CYCLES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        apply    = 1'b0;
        finish   = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (tick && !hold) begin
                    s_d.phase = PH_WARN;
                    s_d.cnt   = WARN_LAST;
                end
            end
            PH_WARN: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (hold) begin
                    s_d.phase = PH_IDLE;
                end else begin
                    apply     = 1'b1;
                    s_d.phase = PH_UPD;
                    s_d.cnt   = UPD_LAST;
                end
            end
            PH_UPD: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    finish    = 1'b1;
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.phase != PH_IDLE);
    assign done = s_q.done;

endmodule

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      bin_mode,
    input  logic      h24_mode,
    output rtc_time_t nxt
);

    logic [7:0] s_v, m_v, h_v, dw_v, dm_v, mo_v, yr_v, dim_v;
    logic [7:0] h_next, h_enc;
    logic       pm_now, pm_next;
    logic       c_min, c_hour, c_day, c_mon, c_year;

    always_comb begin
        s_v    = field_to_bin(cur.sec, bin_mode);
        m_v    = field_to_bin(cur.min, bin_mode);
        h_v    = field_to_bin(h24_mode ? cur.hour : {1'b0, cur.hour[6:0]}, bin_mode);
        pm_now = ~h24_mode & cur.hour[HB_PM];
        dw_v   = field_to_bin(cur.dow, bin_mode);
        dm_v   = field_to_bin(cur.dom, bin_mode);
        mo_v   = field_to_bin(cur.mon, bin_mode);
        yr_v   = field_to_bin(cur.year, bin_mode);
        dim_v  = days_in_month(mo_v, yr_v);

        nxt     = cur;
        c_hour  = 1'b0;
        c_day   = 1'b0;
        c_mon   = 1'b0;
        c_year  = 1'b0;
        h_next  = h_v;
        h_enc   = '0;
        pm_next = pm_now;

        c_min   = (s_v >= 8'd59);
        nxt.sec = field_from_bin(c_min ? 8'd0 : s_v + 8'd1, bin_mode);

        if (c_min) begin
            c_hour  = (m_v >= 8'd59);
            nxt.min = field_from_bin(c_hour ? 8'd0 : m_v + 8'd1, bin_mode);
        end

        if (c_hour) begin
            if (h24_mode) begin
                c_day    = (h_v >= 8'd23);
                nxt.hour = field_from_bin(c_day ? 8'd0 : h_v + 8'd1, bin_mode);
            end else begin
                h_next   = (h_v >= 8'd12) ? 8'd1 : h_v + 8'd1;
                pm_next  = (h_v == 8'd11) ? ~pm_now : pm_now;
                c_day    = (h_v == 8'd11) && pm_now;
                h_enc    = field_from_bin(h_next, bin_mode);
                nxt.hour = {pm_next, h_enc[6:0]};
            end
        end

        if (c_day) begin
            nxt.dow = field_from_bin((dw_v >= 8'd7) ? 8'd1 : dw_v + 8'd1, bin_mode);
            c_mon   = (dm_v >= dim_v);
            nxt.dom = field_from_bin(c_mon ? 8'd1 : dm_v + 8'd1, bin_mode);
        end

        if (c_mon) begin
            c_year  = (mo_v >= 8'd12);
            nxt.mon = field_from_bin(c_year ? 8'd1 : mo_v + 8'd1, bin_mode);
        end

        if (c_year) begin
            nxt.year = field_from_bin((yr_v >= 8'd99) ? 8'd0 : yr_v + 8'd1, bin_mode);
        end
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int FIELDS = 3,
    parameter int FW     = 8
) (
    input  logic [FIELDS-1:0][FW-1:0] now_v,
    input  logic [FIELDS-1:0][FW-1:0] alarm_v,
    output logic                      all_match
);

    localparam logic [1:0] WILDCARD = 2'b11;

    logic [FIELDS-1:0] hit;

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        assign hit[i] = (alarm_v[i][FW-1:FW-2] == WILDCARD) || (alarm_v[i] == now_v[i]);
    end

    assign all_match = &hit;

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
#(
    parameter int WARN_CYCLES = 4,
    parameter int UPD_CYCLES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              update_pending,
    output logic              update_done,
    output logic              alarm_hit
);

    localparam int AL_FIELDS = 3;

    typedef struct packed {
        rtc_time_t         tm;
        logic [DATA_W-1:0] al_sec;
        logic [DATA_W-1:0] al_min;
        logic [DATA_W-1:0] al_hour;
        logic              hold;
        logic              bin_mode;
        logic              h24_mode;
        logic              alarm_hit;
    } tk_state_t;

    tk_state_t r_d, r_q;
    rtc_time_t tm_next;
    logic      seq_busy, seq_apply, seq_finish, seq_done;
    logic      al_all;
    logic [AL_FIELDS-1:0][DATA_W-1:0] cmp_now, cmp_alarm;

    rtc_sequencer #(
        .WARN_CYCLES(WARN_CYCLES),
        .UPD_CYCLES (UPD_CYCLES)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sec_tick),
        .hold  (r_q.hold),
        .busy  (seq_busy),
        .apply (seq_apply),
        .finish(seq_finish),
        .done  (seq_done)
    );

    rtc_calendar_next u_next (
        .cur     (r_q.tm),
        .bin_mode(r_q.bin_mode),
        .h24_mode(r_q.h24_mode),
        .nxt     (tm_next)
    );

    assign cmp_now   = {r_q.tm.hour, r_q.tm.min, r_q.tm.sec};
    assign cmp_alarm = {r_q.al_hour, r_q.al_min, r_q.al_sec};

    rtc_alarm_cmp #(
        .FIELDS(AL_FIELDS),
        .FW    (DATA_W)
    ) u_alarm (
        .now_v    (cmp_now),
        .alarm_v  (cmp_alarm),
        .all_match(al_all)
    );

    always_comb begin
        r_d           = r_q;
        r_d.alarm_hit = seq_finish && al_all;
        if (reg_we) begin
            case (reg_addr)
                A_SEC:     r_d.tm.sec  = reg_wdata;
                A_SEC_AL:  r_d.al_sec  = reg_wdata;
                A_MIN:     r_d.tm.min  = reg_wdata;
                A_MIN_AL:  r_d.al_min  = reg_wdata;
                A_HOUR:    r_d.tm.hour = reg_wdata;
                A_HOUR_AL: r_d.al_hour = reg_wdata;
                A_DOW:     r_d.tm.dow  = reg_wdata;
                A_DOM:     r_d.tm.dom  = reg_wdata;
                A_MON:     r_d.tm.mon  = reg_wdata;
                A_YEAR:    r_d.tm.year = reg_wdata;
                A_CTRL: begin
                    r_d.hold     = reg_wdata[CB_HOLD];
                    r_d.bin_mode = reg_wdata[CB_BIN];
                    r_d.h24_mode = reg_wdata[CB_H24];
                end
                default: ;
            endcase
        end
        // The advance owns the time registers in the cycle it happens.
        if (seq_apply) begin
            r_d.tm = tm_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.tm        <= '{sec: 8'd0, min: 8'd0, hour: 8'd0, dow: 8'd1,
                               dom: 8'd1, mon: 8'd1, year: 8'd0};
            r_q.al_sec    <= '0;
            r_q.al_min    <= '0;
            r_q.al_hour   <= '0;
            r_q.hold      <= 1'b0;
            r_q.bin_mode  <= 1'b0;
            r_q.h24_mode  <= 1'b1;
            r_q.alarm_hit <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SEC:     reg_rdata = r_q.tm.sec;
            A_SEC_AL:  reg_rdata = r_q.al_sec;
            A_MIN:     reg_rdata = r_q.tm.min;
            A_MIN_AL:  reg_rdata = r_q.al_min;
            A_HOUR:    reg_rdata = r_q.tm.hour;
            A_HOUR_AL: reg_rdata = r_q.al_hour;
            A_DOW:     reg_rdata = r_q.tm.dow;
            A_DOM:     reg_rdata = r_q.tm.dom;
            A_MON:     reg_rdata = r_q.tm.mon;
            A_YEAR:    reg_rdata = r_q.tm.year;
            A_STAT:    reg_rdata[SB_PEND] = seq_busy;
            A_CTRL: begin
                reg_rdata[CB_HOLD] = r_q.hold;
                reg_rdata[CB_BIN]  = r_q.bin_mode;
                reg_rdata[CB_H24]  = r_q.h24_mode;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign update_pending = seq_busy;
    assign update_done    = seq_done;
    assign alarm_hit      = r_q.alarm_hit;

endmodule

// File: rtl/rtc_timekeeper_chk.sv
module rtc_timekeeper_chk #(
    parameter int WARN_CYCLES = 4,
    parameter int UPD_CYCLES  = 8
) (
    input logic clk,
    input logic rst_n,
    input logic sec_tick,
    input logic hold,
    input logic update_pending,
    input logic update_done,
    input logic alarm_hit
);

    localparam int WINDOW = WARN_CYCLES + UPD_CYCLES;
    localparam int LW     = $clog2(WINDOW + 2);

    logic [LW-1:0] pend_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_len <= '0;
        end else if (update_pending) begin
            pend_len <= pend_len + 1'b1;
        end else begin
            pend_len <= '0;
        end
    end

    assert_tick_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_pending && sec_tick && !hold) |=> update_pending);

    assert_window_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        update_done |-> (pend_len == LW'(WINDOW)));

    assert_done_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        update_done |-> $fell(update_pending));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        update_done |=> !update_done);

    assert_hold_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_pending && sec_tick && hold) |=> !update_pending);

    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        update_pending |-> (pend_len < LW'(WINDOW)));

    assert_alarm_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> update_done);

endmodule

bind rtc_timekeeper rtc_timekeeper_chk #(
    .WARN_CYCLES(WARN_CYCLES),
    .UPD_CYCLES (UPD_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_tick      (sec_tick),
    .hold          (r_q.hold),
    .update_pending(update_pending),
    .update_done   (update_done),
    .alarm_hit     (alarm_hit)
);

// File: tb/rtc_timekeeper_bench.sv
module rtc_timekeeper_bench;

    localparam int WARN = 3;
    localparam int UPD  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       update_pending, update_done, alarm_hit;

    int n_checks = 0;
    int n_fail   = 0;
    int done_total = 0;

    always #2 clk = ~clk;

    always @(negedge clk) if (update_done) done_total <= done_total + 1;

    rtc_timekeeper #(.WARN_CYCLES(WARN), .UPD_CYCLES(UPD)) u_rtc_timekeeper (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .update_pending(update_pending), .update_done(update_done), .alarm_hit(alarm_hit)
    );

    function automatic int enc(int v, int bin);
        return (bin != 0) ? v : (v / 10) * 16 + (v % 10);
    endfunction

    function automatic int model_dim(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(v);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 4'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic chk_reg(input string req, input string what, input int a, input int exp);
        int v;
        rd(a, v);
        chk(req, what, v, exp);
    endtask

    task automatic pulse_tick();
        @(negedge clk) sec_tick = 1'b1;
        @(negedge clk) sec_tick = 1'b0;
    endtask

    task automatic run_update(output int d, output int a);
        pulse_tick();
        repeat (WARN + UPD) @(negedge clk);
        d = int'(update_done);
        a = int'(alarm_hit);
    endtask

    task automatic load_time(input int s, input int m, input int h, input int dw,
                             input int dm, input int mo, input int yr);
        wr(0, s); wr(2, m); wr(4, h); wr(6, dw); wr(7, dm); wr(8, mo); wr(9, yr);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic test_reset_and_map();
        int v;
        chk("R1", "pending after reset", int'(update_pending), 0);
        chk("R1", "done after reset", int'(update_done), 0);
        chk("R1", "alarm after reset", int'(alarm_hit), 0);
        for (int a = 0; a < 10; a++) begin
            rd(a, v);
            chk("R1", $sformatf("reset value addr %0d", a), v,
                (a == 6 || a == 7 || a == 8) ? 1 : 0);
        end
        chk_reg("R1", "status reset", 10, 8'h00);
        chk_reg("R1", "control reset", 11, 8'h02);
        for (int a = 0; a < 10; a++) wr(a, 8'h13 + a * 8'h11);
        for (int a = 0; a < 10; a++)
            chk_reg("R1", $sformatf("readback addr %0d", a), a, (8'h13 + a * 8'h11) & 8'hFF);
        wr(10, 8'hFF);
        chk_reg("R1", "status not writable", 10, 8'h00);
        wr(11, 8'h79);
        chk_reg("R1", "control masked", 11, 8'h00);
        wr(11, 8'h02);
        wr(1, 0); wr(3, 0); wr(5, 0);
    endtask

    task automatic test_timing();
        load_time(8'h10, 8'h00, 8'h05, 1, 1, 1, 0);
        pulse_tick();
        chk("R2", "pending after accept", int'(update_pending), 1);
        chk_reg("R1", "status while pending", 10, 8'h80);
        chk_reg("R2", "seconds held at accept", 0, 8'h10);
        repeat (WARN - 1) @(negedge clk);
        chk("R2", "pending before advance", int'(update_pending), 1);
        chk_reg("R2", "seconds before advance", 0, 8'h10);
        @(negedge clk);
        chk_reg("R2", "seconds at advance", 0, 8'h11);
        repeat (UPD - 1) @(negedge clk);
        chk("R2", "pending last cycle", int'(update_pending), 1);
        chk("R3", "done before end", int'(update_done), 0);
        @(negedge clk);
        chk("R2", "pending dropped", int'(update_pending), 0);
        chk("R3", "done at end", int'(update_done), 1);
        @(negedge clk);
        chk("R3", "done one cycle", int'(update_done), 0);
    endtask

    task automatic test_busy_tick();
        wr(0, 8'h20);
        pulse_tick();
        pulse_tick();
        repeat (WARN + UPD - 2) @(negedge clk);
        chk("R5", "done on original schedule", int'(update_done), 1);
        repeat (2) @(negedge clk);
        chk("R5", "no restart", int'(update_pending), 0);
        chk_reg("R5", "single advance", 0, 8'h21);
    endtask

    task automatic test_hold();
        int base;
        wr(0, 8'h30);
        wr(11, 8'h82);
        base = done_total;
        pulse_tick();
        chk("R4", "held tick no pending", int'(update_pending), 0);
        repeat (WARN + UPD + 2) @(negedge clk);
        chk_reg("R4", "held time unchanged", 0, 8'h30);
        chk("R4", "held no done", done_total - base, 0);
        wr(11, 8'h02);
        wr(0, 8'h40);
        base = done_total;
        pulse_tick();
        wr(11, 8'h82);
        @(negedge clk);
        chk("R4", "abort drops pending", int'(update_pending), 0);
        repeat (UPD + 2) @(negedge clk);
        chk_reg("R4", "abort time unchanged", 0, 8'h40);
        chk("R4", "abort no done", done_total - base, 0);
        wr(11, 8'h02);
    endtask

    task automatic test_sec_min();
        int d, a;
        for (int b = 0; b < 2; b++) begin
            wr(11, b * 4 + 2);
            for (int s = 0; s < 60; s++) begin
                wr(0, enc(s, b)); wr(2, enc(5, b)); wr(4, enc(10, b));
                run_update(d, a);
                chk("R3", "done per update", d, 1);
                chk_reg("R6", $sformatf("sec from %0d bin %0d", s, b), 0, enc((s + 1) % 60, b));
                chk_reg("R6", $sformatf("min carry at sec %0d", s), 2, enc(s == 59 ? 6 : 5, b));
            end
            for (int m = 0; m < 60; m++) begin
                wr(0, enc(59, b)); wr(2, enc(m, b)); wr(4, enc(10, b));
                run_update(d, a);
                chk_reg("R6", $sformatf("min from %0d bin %0d", m, b), 2, enc((m + 1) % 60, b));
                chk_reg("R6", $sformatf("hour carry at min %0d", m), 4, enc(m == 59 ? 11 : 10, b));
            end
        end
    endtask

    task automatic test_hours();
        int d, a, hn, pn, carry;
        for (int b = 0; b < 2; b++) begin
            wr(11, b * 4 + 2);
            for (int h = 0; h < 24; h++) begin
                load_time(enc(59, b), enc(59, b), enc(h, b), enc(3, b), enc(10, b), enc(5, b), enc(20, b));
                run_update(d, a);
                chk_reg("R7", $sformatf("hour24 from %0d bin %0d", h, b), 4, enc((h + 1) % 24, b));
                chk_reg("R7", $sformatf("date carry at hour %0d", h), 7, enc(h == 23 ? 11 : 10, b));
            end
            wr(11, b * 4);
            for (int pm = 0; pm < 2; pm++) begin
                for (int h = 1; h <= 12; h++) begin
                    hn = (h == 12) ? 1 : h + 1;
                    pn = (h == 11) ? 1 - pm : pm;
                    carry = (h == 11 && pm == 1) ? 1 : 0;
                    load_time(enc(59, b), enc(59, b), enc(h, b) + pm * 128, enc(3, b),
                              enc(10, b), enc(5, b), enc(20, b));
                    run_update(d, a);
                    chk_reg("R8", $sformatf("hour12 from %0d pm %0d bin %0d", h, pm, b), 4,
                            enc(hn, b) + pn * 128);
                    chk_reg("R8", $sformatf("date carry hour12 %0d pm %0d", h, pm), 7,
                            enc(10 + carry, b));
                end
            end
        end
        wr(11, 8'h02);
    endtask

    task automatic test_calendar();
        int d, a, dim, dw;
        for (int b = 0; b < 2; b++) begin
            wr(11, b * 4 + 2);
            for (int y = 0; y < 4; y++) begin
                for (int m = 1; m <= 12; m++) begin
                    dim = model_dim(m, y);
                    dw = (m + y) % 7 + 1;
                    load_time(enc(59, b), enc(59, b), enc(23, b), enc(dw, b), enc(dim, b),
                              enc(m, b), enc(y, b));
                    run_update(d, a);
                    chk_reg("R9", $sformatf("dom wrap m %0d y %0d", m, y), 7, enc(1, b));
                    chk_reg("R9", $sformatf("month m %0d y %0d", m, y), 8, enc(m % 12 + 1, b));
                    chk_reg("R9", $sformatf("year m %0d y %0d", m, y), 9, enc(m == 12 ? y + 1 : y, b));
                    chk_reg("R9", $sformatf("dow from %0d", dw), 6, enc(dw % 7 + 1, b));
                end
                load_time(enc(59, b), enc(59, b), enc(23, b), enc(2, b), enc(28, b), enc(2, b), enc(y, b));
                run_update(d, a);
                chk_reg("R9", $sformatf("feb 28 dom y %0d", y), 7, enc((y % 4 == 0) ? 29 : 1, b));
                chk_reg("R9", $sformatf("feb 28 month y %0d", y), 8, enc((y % 4 == 0) ? 2 : 3, b));
            end
            load_time(enc(59, b), enc(59, b), enc(23, b), enc(7, b), enc(31, b), enc(12, b), enc(99, b));
            run_update(d, a);
            chk_reg("R9", "year wrap", 9, enc(0, b));
            chk_reg("R9", "year wrap month", 8, enc(1, b));
            chk_reg("R9", "year wrap dow", 6, enc(1, b));
        end
        wr(11, 8'h02);
    endtask

    task automatic test_alarm();
        int d, a, exp;
        load_time(8'h29, 8'h15, 8'h08, 1, 1, 1, 0);
        wr(1, 8'h30); wr(3, 8'h15); wr(5, 8'h08);
        run_update(d, a);
        chk("R10", "exact match pulse", a, 1);
        chk("R10", "exact match with done", d, 1);
        @(negedge clk);
        chk("R10", "alarm one cycle", int'(alarm_hit), 0);
        run_update(d, a);
        chk("R10", "no match next second", a, 0);
        for (int mask = 0; mask < 8; mask++) begin
            for (int wild = 0; wild < 2; wild++) begin
                load_time(8'h29, 8'h16, 8'h09, 1, 1, 1, 0);
                wr(1, ((mask & 1) != 0) ? ((wild != 0) ? 8'hC0 + mask : 8'h45) : 8'h30);
                wr(3, ((mask & 2) != 0) ? ((wild != 0) ? 8'hC5 : 8'h45) : 8'h16);
                wr(5, ((mask & 4) != 0) ? ((wild != 0) ? 8'hFF : 8'h45) : 8'h09);
                run_update(d, a);
                exp = (wild != 0 || mask == 0) ? 1 : 0;
                chk((wild != 0) ? "R11" : "R10",
                    $sformatf("alarm mask %0d wildcard %0d", mask, wild), a, exp);
            end
        end
        load_time(8'h29, 8'h16, 8'h09, 1, 1, 1, 0);
        wr(1, 8'h80); wr(3, 8'h16); wr(5, 8'h09);
        run_update(d, a);
        chk("R11", "single top bit is not wildcard", a, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_and_map();
        test_timing();
        test_busy_tick();
        test_hold();
        test_sec_min();
        test_hours();
        test_calendar();
        test_alarm();
        finish_run();
    end

endmodule